// File: doc/BRIEF.md
# FIFO Flag Threshold Offset Configuration Unit

This block keeps the two thresholds that a FIFO's programmable flags compare against: the empty offset `n`, which sets how close to empty the almost-empty flag fires, and the full offset `m`, which does the same for almost-full. Both values go out at all times to the flag generator on `empty_ofs` and `full_ofs`. The block does not contain the FIFO memory, its pointers or the flag comparators.

While the synchronous master reset `rst` is high, the block samples three pins on each clock edge. The access pin `ofs_access_n` sets the programming mode for the rest of the session: high gives serial, low gives parallel. That same pin, together with the two select pins `dflt_sel`, picks one of eight built-in default offsets, and the block loads that value into both registers. After reset, holding `ofs_access_n` low sends write and read strobes to the offset registers rather than to the FIFO. Writes take the values from the parallel bus or one bit at a time from `ser_in`, depending on the mode. Reads always return the values on the parallel `rd_data` port, whichever mode is active.

Top module: `ofs_cfg_unit`

## Requirements
- R1: `serial_mode` takes the value of `ofs_access_n` sampled on every clock edge at which `rst` is high (1 = serial, 0 = parallel).
- R2: On every clock edge with `rst` high, both offsets load the default selected by the code {`ofs_access_n`,`dflt_sel[1]`,`dflt_sel[0]`}: 100→1023, 010→511, 001→255, 000→127, 011→63, 110→31, 101→15, 111→7. Any default larger than DEPTH-1 is capped at DEPTH-1.
- R3: While `ofs_access_n` is high after reset, `wr_en` and `rd_en` have no effect on the offsets, on `rd_data` or on the write and read sequence positions.
- R4: In parallel mode, a write access (`ofs_access_n` low, `wr_en` high) copies `wr_data` into `n` on the first access after reset and into `m` on the second. The target then keeps alternating, so `n` and `m` can be rewritten any number of times. Each new value appears on the outputs one clock after the access edge.
- R5: In serial mode, each write access stores `ser_in` into a single bit. The first W accesses fill bits 0 to W-1 of `n` in that order, the next W accesses fill bits 0 to W-1 of `m`, and the sequence then wraps to bit 0 of `n` (W = clog2(DEPTH)).
- R6: In serial mode `wr_data` has no effect. In parallel mode `ser_in` has no effect.
- R7: A read access (`ofs_access_n` low, `rd_en` high) puts `n` on `rd_data` one clock later, the next read access puts `m`, and the reads keep alternating from there. Reset restarts the order at `n` and clears `rd_data` to 0. Between read accesses, `rd_data` keeps its value.
- R8: Read accesses never change the offsets and work in both modes. When a read and a write happen in the same cycle, the read returns the value from before the write.
- R9: `serial_mode` stays constant between resets. A new reset restarts both the write sequence and the read sequence.
- R10: `empty_ofs` and `full_ofs` show the current `n` and `m` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| ofs_access_n | input | 1 | Mode pin during reset; low afterwards routes strobes to the offsets |
| dflt_sel | input | 2 | Default offset select, sampled during reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | clog2(DEPTH) | Parallel offset write value |
| ser_in | input | 1 | Serial offset bit |
| rd_data | output | clog2(DEPTH) | Offset readback value |
| empty_ofs | output | clog2(DEPTH) | Current empty offset n |
| full_ofs | output | clog2(DEPTH) | Current full offset m |
| serial_mode | output | 1 | Latched programming mode (1 = serial) |

## Verification
The bench first applies reset with each of the eight pin codes. This separates every default value and both modes, and it catches a swapped select bit or a wrong table entry.

Directed sequences come next:
- In parallel mode, three writes show that the target alternates and wraps back to `n`.
- In serial mode, a walking pattern longer than 2W bits shows the bit order, the switch from `n` to `m` and the wrap to `n`.
- Writes with the unused input toggled in each mode show that the unused input is ignored.
- Reads interleaved with writes, including a read and a write in the same cycle, show the readback order and that a read returns the value from before a write in the same cycle.
- Boundary values 0 and DEPTH-1 are written.

Random strobes with `$urandom` then mix access-pin levels, writes and reads in both modes. Any case where the pin's gating or a sequence position drifts from the model shows up as a mismatch.

// File: rtl/ofs_cfg_pkg.sv
package ofs_cfg_pkg;

    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } prog_mode_e;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    typedef struct packed {
        logic       valid;
        ofs_sel_e   target;
        prog_mode_e mode;
    } wr_cmd_t;

    // Exponent k of the default 2^k - 1, indexed by {access pin, sel1, sel0}
    function automatic int unsigned dflt_exp(input logic [2:0] code);
        case (code)
            3'b100:  return 10;
            3'b010:  return 9;
            3'b001:  return 8;
            3'b000:  return 7;
            3'b011:  return 6;
            3'b110:  return 5;
            3'b101:  return 4;
            default: return 3;
        endcase
    endfunction

    // Default offset, capped to the legal range 0..depth-1
    function automatic int unsigned dflt_value(input logic [2:0] code,
                                               input int unsigned depth);
        int unsigned v;
        v = (32'd1 << dflt_exp(code)) - 32'd1;
        if (v > depth - 1) v = depth - 1;
        return v;
    endfunction

endpackage

// File: rtl/ofs_write_seq.sv
module ofs_write_seq
    import ofs_cfg_pkg::*;
#(
    parameter int unsigned OFS_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  prog_mode_e               mode,
    input  logic                     acc,
    output wr_cmd_t                  cmd,
    output logic [$clog2(OFS_W)-1:0] bit_idx
);
    localparam int unsigned SEQ_LEN = 2 * OFS_W;
    localparam int unsigned CNT_W   = $clog2(SEQ_LEN);
    localparam int unsigned IDX_W   = $clog2(OFS_W);

    logic [CNT_W-1:0] pos_q;
    logic             upper;

    assign upper = (pos_q >= CNT_W'(OFS_W));

    always_comb begin
        cmd.valid = acc;
        cmd.mode  = mode;
        if (mode == MODE_SER) cmd.target = upper ? SEL_FULL : SEL_EMPTY;
        else                  cmd.target = pos_q[0] ? SEL_FULL : SEL_EMPTY;
        bit_idx = upper ? IDX_W'(pos_q - CNT_W'(OFS_W)) : IDX_W'(pos_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (acc) begin
            if (mode == MODE_SER)
                pos_q <= (pos_q == CNT_W'(SEQ_LEN - 1)) ? '0 : pos_q + 1'b1;
            else
                pos_q <= pos_q[0] ? CNT_W'(0) : CNT_W'(1);
        end
    end

    // Parallel accesses alternate between the two registers
    p_par_alt_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && mode == MODE_PAR) |=> (cmd.target != $past(cmd.target)));

    // Serial position never leaves the 2W-bit sequence
    p_seq_bound_r5: assert property (@(posedge clk) disable iff (rst)
        acc |=> (pos_q < CNT_W'(SEQ_LEN)));

endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank
    import ofs_cfg_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned OFS_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [2:0]               dflt_code,
    input  wr_cmd_t                  cmd,
    input  logic [$clog2(OFS_W)-1:0] bit_idx,
    input  logic [OFS_W-1:0]         pdata,
    input  logic                     sbit,
    output logic [OFS_W-1:0]         empty_ofs,
    output logic [OFS_W-1:0]         full_ofs
);
    localparam int unsigned NREG = 2;

    logic [OFS_W-1:0] ofs_q [NREG];
    logic [OFS_W-1:0] dflt;

    assign dflt = OFS_W'(dflt_value(dflt_code, DEPTH));

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                ofs_q[g] <= dflt;
            end else if (cmd.valid && (int'(cmd.target) == g)) begin
                if (cmd.mode == MODE_SER) ofs_q[g][bit_idx] <= sbit;
                else                      ofs_q[g]          <= pdata;
            end
        end
    end

    assign empty_ofs = ofs_q[0];
    assign full_ofs  = ofs_q[1];

    // A serial access changes at most one stored bit
    p_ser_one_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && cmd.mode == MODE_SER) |=>
        (($countones(ofs_q[0] ^ $past(ofs_q[0])) +
          $countones(ofs_q[1] ^ $past(ofs_q[1]))) <= 1));

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback #(
    parameter int unsigned OFS_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_acc,
    input  logic [OFS_W-1:0] n_val,
    input  logic [OFS_W-1:0] m_val,
    output logic [OFS_W-1:0] rdata
);
    logic rptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q <= 1'b0;
            rdata  <= '0;
        end else if (rd_acc) begin
            rptr_q <= ~rptr_q;
            rdata  <= rptr_q ? m_val : n_val;
        end
    end

    // Each read access advances the pointer; idle cycles keep the data
    p_rd_alt_r7: assert property (@(posedge clk) disable iff (rst)
        rd_acc |=> (rptr_q != $past(rptr_q)));

    p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_acc |=> ($stable(rptr_q) && $stable(rdata)));

endmodule

// File: rtl/ofs_cfg_unit.sv
module ofs_cfg_unit
    import ofs_cfg_pkg::*;
#(
    parameter int unsigned DEPTH = 1024
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ofs_access_n,
    input  logic [1:0]                 dflt_sel,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_data,
    input  logic                       ser_in,
    output logic [$clog2(DEPTH)-1:0]   rd_data,
    output logic [$clog2(DEPTH)-1:0]   empty_ofs,
    output logic [$clog2(DEPTH)-1:0]   full_ofs,
    output logic                       serial_mode
);
    localparam int unsigned OFS_W = $clog2(DEPTH);
    localparam int unsigned IDX_W = $clog2(OFS_W);

    prog_mode_e       mode_q;
    wr_cmd_t          cmd;
    logic [IDX_W-1:0] bit_idx;
    logic             wr_acc;
    logic             rd_acc;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= ofs_access_n ? MODE_SER : MODE_PAR;
    end

    assign serial_mode = (mode_q == MODE_SER);
    assign wr_acc      = !ofs_access_n && wr_en;
    assign rd_acc      = !ofs_access_n && rd_en;

    ofs_write_seq #(.OFS_W(OFS_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_q),
        .acc     (wr_acc),
        .cmd     (cmd),
        .bit_idx (bit_idx)
    );

    ofs_reg_bank #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .dflt_code ({ofs_access_n, dflt_sel}),
        .cmd       (cmd),
        .bit_idx   (bit_idx),
        .pdata     (wr_data),
        .sbit      (ser_in),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    ofs_readback #(.OFS_W(OFS_W)) u_rb (
        .clk    (clk),
        .rst    (rst),
        .rd_acc (rd_acc),
        .n_val  (empty_ofs),
        .m_val  (full_ofs),
        .rdata  (rd_data)
    );

    p_mode_fixed_r9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(serial_mode));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ofs_access_n |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(rd_data)));

    p_rd_keep_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_acc |=> ($stable(empty_ofs) && $stable(full_ofs)));

endmodule

// File: tb/ofs_cfg_unit_test.sv
module ofs_cfg_unit_test;
    localparam int unsigned DEPTH = 1024;
    localparam int unsigned W     = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ofs_access_n = 1'b1;
    logic [1:0]   dflt_sel = 2'b00;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         ser_in = 1'b0;
    logic [W-1:0] rd_data, empty_ofs, full_ofs;
    logic         serial_mode;

    always #10 clk = ~clk;

    ofs_cfg_unit #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .ofs_access_n(ofs_access_n), .dflt_sel(dflt_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .ser_in(ser_in),
        .rd_data(rd_data), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .serial_mode(serial_mode)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] exp_n, exp_m, exp_rd;
    bit exp_ser;
    int wcnt, rptr;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dflt(input bit [2:0] c);
        int v;
        case (c)
            3'b100: v = 1023; 3'b010: v = 511; 3'b001: v = 255; 3'b000: v = 127;
            3'b011: v = 63;   3'b110: v = 31;  3'b101: v = 15;  default: v = 7;
        endcase
        if (v > DEPTH - 1) v = DEPTH - 1;
        return v;
    endfunction

    // Called at a falling edge; returns at a falling edge
    task automatic do_reset(input bit l, input bit [1:0] s);
        rst = 1'b1; ofs_access_n = l; dflt_sel = s; wr_en = 0; rd_en = 0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; ofs_access_n = 1'b1; dflt_sel = ~s;
        exp_ser = l; exp_n = W'(dflt({l, s})); exp_m = exp_n;
        exp_rd = '0; wcnt = 0; rptr = 0;
        chk("R1 mode", int'(serial_mode), int'(exp_ser));
        chk("R2 n default", int'(empty_ofs), int'(exp_n));
        chk("R2 m default", int'(full_ofs), int'(exp_m));
        chk("R7 rd_data reset", int'(rd_data), 0);
    endtask

    task automatic step(input bit l, input bit w, input bit r,
                        input logic [W-1:0] pd, input bit sb);
        string tag;
        ofs_access_n = l; wr_en = w; rd_en = r; wr_data = pd; ser_in = sb;
        @(posedge clk);
        if (!l && r) begin
            exp_rd = (rptr != 0) ? exp_m : exp_n;
            rptr ^= 1;
        end
        if (!l && w) begin
            if (exp_ser) begin
                if (wcnt < W) exp_n[wcnt] = sb;
                else          exp_m[wcnt - W] = sb;
                wcnt = (wcnt + 1) % (2 * W);
            end else begin
                if ((wcnt & 1) == 0) exp_n = pd;
                else                 exp_m = pd;
                wcnt ^= 1;
            end
        end
        @(negedge clk);
        if (l)      tag = "R3";
        else if (w) tag = exp_ser ? "R5/R6" : "R4/R6";
        else        tag = "R8";
        chk({tag, " R10 n"}, int'(empty_ofs), int'(exp_n));
        chk({tag, " R10 m"}, int'(full_ofs), int'(exp_m));
        chk(r ? "R7 rd_data" : "R7 rd_data hold", int'(rd_data), int'(exp_rd));
        chk("R9 mode stable", int'(serial_mode), int'(exp_ser));
        wr_en = 0; rd_en = 0; ofs_access_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0f5e));
        @(negedge clk);
        // R1, R2: every pin code
        for (int c = 0; c < 8; c++) begin
            bit [2:0] cc = 3'(c);
            do_reset(cc[2], cc[1:0]);
        end

        // Parallel mode, default 127
        do_reset(1'b0, 2'b00);
        step(1, 1, 1, 10'd5, 1);          // R3: strobes ignored with pin high
        step(0, 1, 0, 10'd300, 1);        // R4: first -> n
        step(0, 1, 0, 10'd44, 0);         // R4: second -> m
        step(0, 1, 0, 10'd1023, 1);       // R4: wraps to n, boundary DEPTH-1
        step(0, 1, 0, 10'd0, 1);          // R4: m boundary 0, R6 ser_in ignored
        step(0, 0, 1, 10'd0, 0);          // R7: n first
        step(1, 0, 1, 10'd0, 0);          // R3: read ignored
        step(0, 0, 1, 10'd0, 0);          // R7: m
        step(0, 1, 1, 10'd77, 0);         // R8: read old n, write n
        step(0, 0, 1, 10'd0, 0);          // R7: m
        step(0, 0, 1, 10'd0, 0);          // R7: new n

        // Serial mode, default 1023
        do_reset(1'b1, 2'b00);
        for (int i = 0; i < 2 * W + 3; i++)
            step(0, 1, 0, W'($urandom), (i % 3) == 0);   // R5 bit order, R6 bus ignored
        step(0, 0, 1, '0, 0);
        step(0, 1, 1, 10'h3FF, 1);        // R8 read/write same cycle
        step(0, 0, 1, '0, 0);

        // R9: re-reset restarts sequences; random traffic in both modes
        for (int ph = 0; ph < 4; ph++) begin
            do_reset(ph[0], 2'($urandom));
            for (int k = 0; k < 400; k++)
                step(($urandom % 5) == 0, $urandom % 2, $urandom % 2,
                     W'($urandom), $urandom % 2);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule